// File: doc/BRIEF.md
# Positional PID Controller with Filtered Measurement Derivative

This block is a sampled, fixed-point feedback controller in positional form. On every sample strobe it takes a signed target value and a signed measurement. It computes the control error as target minus measurement. It then drives a registered, signed command that is the sum of three weighted terms: one proportional to the present error, one proportional to the accumulated error, and one proportional to a low-pass filtered rate of change. The rate-of-change term is built from the measurement only. A jump in the target therefore never produces a derivative spike.

All three gains, the filter strength and the integrator limits are run-time inputs. Setting a gain to zero removes its term, so the same block can be used as a P, PI, PD or full PID loop. The integrator clamps to programmable limits. It also stops accumulating while the command is pinned at a rail in the direction the error pushes (anti-windup). The command itself saturates at the 16-bit signed rails rather than wrapping.

Top module: `pid_loop`

## Requirements
- R1: A synchronous active-high reset clears the command to 0, drops the result strobe, and empties the integrator, the derivative filter and the stored previous measurement.
- R2: The result strobe is high for exactly the one cycle after each cycle with the sample strobe high. The command changes only on that edge and holds its value otherwise.
- R3: Gains are signed Q8.8 (0x0100 is 1.0). With the integral and derivative gains at zero, the command is (kp * (target - measurement)) shifted arithmetically right by 8, which rounds toward minus infinity.
- R4: The integrator adds the current error on every sample. The integral contribution (ki * integrator) >>> 8 uses the integrator value that already includes the current sample.
- R5: The 32-bit signed integrator is clamped to [int_lo, int_hi] whenever it accumulates.
- R6: When the previous command was clamped at the positive rail and the error is positive, or at the negative rail and the error is negative, the integrator keeps its value for that sample.
- R7: The raw derivative is the previous measurement minus the current one. It is zero on the first sample after reset, and a change of target alone leaves it unchanged.
- R8: The filtered derivative moves by (raw - filtered) >>> alpha_shift on each sample. With alpha_shift 0 it equals the raw value. The derivative contribution is (kd * filtered) >>> 8.
- R9: The command saturates to 32767 or -32768 when the sum of the three contributions leaves the 16-bit signed range.
- R10: A gain of zero removes its term, so P, PI, PD and PID combinations each give the sum of only the enabled terms.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single clock |
| rst | input | 1 | Synchronous active-high reset |
| sample_valid | input | 1 | Strobe that advances all state by one sample |
| setpoint | input | 16 | Signed target value |
| measured | input | 16 | Signed measured process value |
| kp | input | 16 | Signed Q8.8 proportional gain |
| ki | input | 16 | Signed Q8.8 integral gain |
| kd | input | 16 | Signed Q8.8 derivative gain |
| alpha_shift | input | 4 | Derivative filter strength as a right-shift count |
| int_hi | input | 32 | Signed upper clamp of the integrator |
| int_lo | input | 32 | Signed lower clamp of the integrator |
| u_out | output | 16 | Registered, saturated signed control command |
| out_valid | output | 1 | One-cycle strobe marking a new command |

## Verification
The embedded properties watch the timing of the strobe, the hold of the command and of the filter state between samples, and the freeze of the integrator while the command sits at a rail. They also check that the integrator stays inside its limits and that the filter passes the raw derivative straight through when alpha_shift is 0. The arithmetic itself can only be shown by the bench's scenarios, which compare each command against an independent model. These scenarios cover the rounding of negative Q8.8 products, the integrator reaching its clamp, the missing kick on a target step, and the decay of the filter over several samples. They also cover both output rails and the return to a clean state after a mid-run reset.

// File: rtl/pid_pkg.sv
package pid_pkg;
  // Which rail, if any, clipped the most recent command
  typedef enum logic [1:0] {
    SAT_NONE = 2'd0,
    SAT_HI   = 2'd1,
    SAT_LO   = 2'd2
  } sat_e;
endpackage

// File: rtl/pid_integrator.sv
module pid_integrator import pid_pkg::*; #(
  parameter int DATA_W = 16,
  parameter int ACC_W  = 32
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     step,
  input  logic signed [DATA_W:0]   err,
  input  logic signed [ACC_W-1:0]  lim_hi,
  input  logic signed [ACC_W-1:0]  lim_lo,
  input  sat_e                     sat_state,
  output logic signed [ACC_W-1:0]  integ_next,
  output logic signed [ACC_W-1:0]  integ_q
);
  localparam int EXT_W = ACC_W - DATA_W;

  logic signed [ACC_W:0] sum_w, hi_x, lo_x;
  logic                  freeze;

  assign sum_w = {integ_q[ACC_W-1], integ_q} + {{EXT_W{err[DATA_W]}}, err};
  assign hi_x  = {lim_hi[ACC_W-1], lim_hi};
  assign lo_x  = {lim_lo[ACC_W-1], lim_lo};

  // anti-windup: hold while the command is pinned in the error's direction
  assign freeze = ((sat_state == SAT_HI) && !err[DATA_W] && (err != '0)) ||
                  ((sat_state == SAT_LO) &&  err[DATA_W]);

  always_comb begin
    if (freeze)            integ_next = integ_q;
    else if (sum_w > hi_x) integ_next = lim_hi;
    else if (sum_w < lo_x) integ_next = lim_lo;
    else                   integ_next = sum_w[ACC_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst)       integ_q <= '0;
    else if (step) integ_q <= integ_next;
  end

  assert_integ_in_limits_R5: assert property (@(posedge clk) disable iff (rst)
    (step && (lim_lo <= lim_hi) && (sat_state == SAT_NONE)) |=>
      ((integ_q >= $past(lim_lo)) && (integ_q <= $past(lim_hi))));

  assert_windup_freeze_hi_R6: assert property (@(posedge clk) disable iff (rst)
    (step && (sat_state == SAT_HI) && (err > 0)) |=> $stable(integ_q));

  assert_windup_freeze_lo_R6: assert property (@(posedge clk) disable iff (rst)
    (step && (sat_state == SAT_LO) && (err < 0)) |=> $stable(integ_q));

  assert_integ_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !step |=> $stable(integ_q));
endmodule

// File: rtl/pid_dfilter.sv
module pid_dfilter #(
  parameter int DATA_W  = 16,
  parameter int SHIFT_W = 4
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      step,
  input  logic signed [DATA_W-1:0]  pv,
  input  logic        [SHIFT_W-1:0] alpha,
  output logic signed [DATA_W+1:0]  df_next,
  output logic signed [DATA_W+1:0]  df_q
);
  localparam int DF_W = DATA_W + 2;

  logic signed [DATA_W-1:0] prev_q;
  logic                     primed_q;
  logic signed [DF_W-1:0]   raw_d;
  logic signed [DF_W:0]     diff, move;

  // derivative on measurement: previous minus current, zero until primed
  assign raw_d = primed_q ? ({{2{prev_q[DATA_W-1]}}, prev_q} - {{2{pv[DATA_W-1]}}, pv})
                          : '0;
  assign diff    = {raw_d[DF_W-1], raw_d} - {df_q[DF_W-1], df_q};
  assign move    = diff >>> alpha;
  assign df_next = df_q + move[DF_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q   <= '0;
      primed_q <= 1'b0;
      df_q     <= '0;
    end else if (step) begin
      prev_q   <= pv;
      primed_q <= 1'b1;
      df_q     <= df_next;
    end
  end

  assert_filter_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !step |=> $stable(df_q));

  assert_filter_bypass_R8: assert property (@(posedge clk) disable iff (rst)
    (step && (alpha == '0)) |=> (df_q == $past(raw_d)));

  assert_first_sample_no_kick_R7: assert property (@(posedge clk) disable iff (rst)
    (step && !primed_q) |=> (df_q == $past(df_q)));
endmodule

// File: rtl/pid_combine.sv
module pid_combine import pid_pkg::*; #(
  parameter int DATA_W = 16,
  parameter int GAIN_W = 16,
  parameter int ACC_W  = 32,
  parameter int FRAC   = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     step,
  input  logic signed [DATA_W:0]   err,
  input  logic signed [ACC_W-1:0]  integ,
  input  logic signed [DATA_W+1:0] df,
  input  logic signed [GAIN_W-1:0] kp,
  input  logic signed [GAIN_W-1:0] ki,
  input  logic signed [GAIN_W-1:0] kd,
  output logic signed [DATA_W-1:0] u_out,
  output logic                     out_valid,
  output sat_e                     sat_state
);
  localparam int ERR_W = DATA_W + 1;
  localparam int DF_W  = DATA_W + 2;
  localparam int SUM_W = ACC_W + GAIN_W + 2;
  localparam logic signed [SUM_W-1:0] OUT_MAX = (SUM_W'(1) << (DATA_W - 1)) - SUM_W'(1);
  localparam logic signed [SUM_W-1:0] OUT_MIN = -OUT_MAX - SUM_W'(1);

  logic signed [SUM_W-1:0] ex, ix, dx, kpx, kix, kdx;
  logic signed [SUM_W-1:0] p_term, i_term, d_term, total;

  assign ex  = {{(SUM_W - ERR_W){err[ERR_W-1]}}, err};
  assign ix  = {{(SUM_W - ACC_W){integ[ACC_W-1]}}, integ};
  assign dx  = {{(SUM_W - DF_W){df[DF_W-1]}}, df};
  assign kpx = {{(SUM_W - GAIN_W){kp[GAIN_W-1]}}, kp};
  assign kix = {{(SUM_W - GAIN_W){ki[GAIN_W-1]}}, ki};
  assign kdx = {{(SUM_W - GAIN_W){kd[GAIN_W-1]}}, kd};

  assign p_term = (ex * kpx) >>> FRAC;
  assign i_term = (ix * kix) >>> FRAC;
  assign d_term = (dx * kdx) >>> FRAC;
  assign total  = p_term + i_term + d_term;

  always_ff @(posedge clk) begin
    if (rst) begin
      u_out     <= '0;
      out_valid <= 1'b0;
      sat_state <= SAT_NONE;
    end else begin
      out_valid <= step;
      if (step) begin
        if (total > OUT_MAX) begin
          u_out     <= OUT_MAX[DATA_W-1:0];
          sat_state <= SAT_HI;
        end else if (total < OUT_MIN) begin
          u_out     <= OUT_MIN[DATA_W-1:0];
          sat_state <= SAT_LO;
        end else begin
          u_out     <= total[DATA_W-1:0];
          sat_state <= SAT_NONE;
        end
      end
    end
  end

  assert_strobe_follows_R2: assert property (@(posedge clk) disable iff (rst)
    step |=> out_valid);

  assert_no_spurious_strobe_R2: assert property (@(posedge clk) disable iff (rst)
    !step |=> !out_valid);

  assert_output_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !step |=> $stable(u_out));

  assert_interior_unclipped_R9: assert property (@(posedge clk) disable iff (rst)
    (out_valid && (u_out != OUT_MAX[DATA_W-1:0]) && (u_out != OUT_MIN[DATA_W-1:0]))
      |-> (sat_state == SAT_NONE));
endmodule

// File: rtl/pid_loop.sv
module pid_loop import pid_pkg::*; #(
  parameter int DATA_W  = 16,
  parameter int GAIN_W  = 16,
  parameter int ACC_W   = 32,
  parameter int FRAC    = 8,
  parameter int SHIFT_W = 4
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      sample_valid,
  input  logic signed [DATA_W-1:0]  setpoint,
  input  logic signed [DATA_W-1:0]  measured,
  input  logic signed [GAIN_W-1:0]  kp,
  input  logic signed [GAIN_W-1:0]  ki,
  input  logic signed [GAIN_W-1:0]  kd,
  input  logic        [SHIFT_W-1:0] alpha_shift,
  input  logic signed [ACC_W-1:0]   int_hi,
  input  logic signed [ACC_W-1:0]   int_lo,
  output logic signed [DATA_W-1:0]  u_out,
  output logic                      out_valid
);
  logic signed [DATA_W:0]   err;
  logic signed [ACC_W-1:0]  integ_next, integ_q;
  logic signed [DATA_W+1:0] df_next, df_q;
  sat_e                     sat_state;

  assign err = {setpoint[DATA_W-1], setpoint} - {measured[DATA_W-1], measured};

  pid_integrator #(.DATA_W(DATA_W), .ACC_W(ACC_W)) u_integ (
    .clk(clk), .rst(rst), .step(sample_valid), .err(err),
    .lim_hi(int_hi), .lim_lo(int_lo), .sat_state(sat_state),
    .integ_next(integ_next), .integ_q(integ_q)
  );

  pid_dfilter #(.DATA_W(DATA_W), .SHIFT_W(SHIFT_W)) u_dfilt (
    .clk(clk), .rst(rst), .step(sample_valid), .pv(measured),
    .alpha(alpha_shift), .df_next(df_next), .df_q(df_q)
  );

  pid_combine #(.DATA_W(DATA_W), .GAIN_W(GAIN_W), .ACC_W(ACC_W), .FRAC(FRAC)) u_comb (
    .clk(clk), .rst(rst), .step(sample_valid), .err(err),
    .integ(integ_next), .df(df_next), .kp(kp), .ki(ki), .kd(kd),
    .u_out(u_out), .out_valid(out_valid), .sat_state(sat_state)
  );

  assert_reset_quiet_R1: assert property (@(posedge clk)
    $past(rst) |-> ((u_out == '0) && !out_valid));
endmodule

// File: tb/pid_loop_test.sv
module pid_loop_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sample_valid = 1'b0;
  logic signed [15:0] setpoint = '0, measured = '0;
  logic signed [15:0] kp = '0, ki = '0, kd = '0;
  logic [3:0] alpha_shift = '0;
  logic signed [31:0] int_hi = 32'sd1000000000, int_lo = -32'sd1000000000;
  logic signed [15:0] u_out;
  logic out_valid;

  always #(CLK_PERIOD/2) clk = ~clk;

  pid_loop uut (
    .clk(clk), .rst(rst), .sample_valid(sample_valid), .setpoint(setpoint),
    .measured(measured), .kp(kp), .ki(ki), .kd(kd), .alpha_shift(alpha_shift),
    .int_hi(int_hi), .int_lo(int_lo), .u_out(u_out), .out_valid(out_valid)
  );

  typedef struct { longint val; string tag; } exp_t;
  exp_t sb[$];
  int checks = 0, errors = 0;
  bit done = 0;

  // reference model state
  longint m_integ, m_df, m_prev;
  bit m_primed;
  int m_sat; // 0 none, 1 high rail, 2 low rail
  longint last_exp = 0;

  task automatic check(input string tag, input longint got, input longint exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic summary();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  task automatic model_clear();
    m_integ = 0; m_df = 0; m_prev = 0; m_primed = 0; m_sat = 0; last_exp = 0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; sample_valid = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    model_clear();
  endtask

  // driver: compute the expected command, queue it, pulse the strobe
  task automatic sample(input int s, input int p, input string tag);
    longint e, ii, raw, df, sum, pt, it, dt, q;
    bit frz;
    exp_t item;
    @(negedge clk);
    setpoint = 16'(s); measured = 16'(p);
    e = longint'(s) - longint'(p);
    frz = (m_sat == 1 && e > 0) || (m_sat == 2 && e < 0);
    ii = m_integ + e;
    if (frz) ii = m_integ;
    else if (ii > longint'(int_hi)) ii = longint'(int_hi);
    else if (ii < longint'(int_lo)) ii = longint'(int_lo);
    raw = m_primed ? (m_prev - longint'(p)) : 0;
    df = m_df + ((raw - m_df) >>> alpha_shift);
    pt = (longint'(kp) * e) >>> 8;
    it = (longint'(ki) * ii) >>> 8;
    dt = (longint'(kd) * df) >>> 8;
    sum = pt + it + dt;
    if (sum > 32767) begin q = 32767; m_sat = 1; end
    else if (sum < -32768) begin q = -32768; m_sat = 2; end
    else begin q = sum; m_sat = 0; end
    m_integ = ii; m_df = df; m_prev = p; m_primed = 1; last_exp = q;
    item.val = q; item.tag = tag;
    sb.push_back(item);
    sample_valid = 1'b1;
    @(negedge clk);
    sample_valid = 1'b0;
  endtask

  task automatic gains(input int p, input int i, input int d, input int a);
    kp = 16'(p); ki = 16'(i); kd = 16'(d); alpha_shift = 4'(a);
  endtask

  // monitor: pop on every result strobe
  always @(negedge clk) begin
    if (!rst && out_valid) begin
      if (sb.size() == 0) check("R2 unexpected strobe", 1, 0);
      else begin
        exp_t it;
        it = sb.pop_front();
        check(it.tag, longint'(u_out), it.val);
      end
    end
  end

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        checks++; errors++;
        $display("FAIL watchdog: got %0d expected %0d cycles", cyc, 100000);
        summary();
      end
    end
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1 u_out in reset", longint'(u_out), 0);
    check("R1 out_valid in reset", longint'(out_valid), 0);
    rst = 1'b0;
    model_clear();

    // R3 / R10: proportional only, including negative rounding
    gains(16'sh0180, 0, 0, 0);
    sample(100, 40, "R3 P 1.5*60");
    sample(-50, 30, "R3 P 1.5*-80");
    gains(16'sh0080, 0, 0, 0);
    sample(0, 3, "R3 P floor of -1.5");
    gains(-16'sh0100, 0, 0, 0);
    sample(7, 0, "R3 negative gain");

    // R2: command holds and no strobe between samples
    repeat (4) @(negedge clk);
    check("R2 hold between samples", longint'(u_out), last_exp);
    check("R2 strobe low between samples", longint'(out_valid), 0);

    // R4: integral accumulation includes current sample
    do_reset();
    gains(0, 16'sh0100, 0, 0);
    sample(10, 0, "R4 PI sum 10");
    sample(20, 0, "R4 PI sum 30");
    sample(0, 5, "R4 PI sum 25");
    gains(16'sh0100, 16'sh0080, 0, 0);
    sample(40, 0, "R10 PI mix");

    // R5: integrator clamp
    do_reset();
    int_hi = 500; int_lo = -400;
    gains(0, 16'sh0100, 0, 0);
    sample(300, 0, "R5 below upper");
    sample(300, 0, "R5 at upper");
    sample(300, 0, "R5 held at upper");
    sample(-1000, 0, "R5 drop");
    sample(-1000, 0, "R5 at lower");
    int_hi = 32'sd1000000000; int_lo = -32'sd1000000000;

    // R6: anti-windup freeze
    do_reset();
    gains(16'sh6400, 16'sh0100, 0, 0);
    sample(1000, 0, "R6 first sample saturates");
    sample(1000, 0, "R6 frozen while railed");
    gains(0, 16'sh0100, 0, 0);
    sample(0, 0, "R6 integrator kept 1000");
    gains(16'sh6400, 16'sh0100, 0, 0);
    sample(-1000, 0, "R6 rail low");
    sample(-1000, 0, "R6 frozen at low rail");
    gains(0, 16'sh0100, 0, 0);
    sample(0, 0, "R6 low-side integrator kept");

    // R7: derivative on measurement, no setpoint kick
    do_reset();
    gains(0, 0, 16'sh0100, 0);
    sample(0, 50, "R7 first sample no kick");
    sample(0, 60, "R7 measurement rise");
    sample(500, 60, "R7 setpoint step no kick");
    sample(-300, 40, "R7 measurement fall");

    // R8: low-pass filtering
    do_reset();
    gains(0, 0, 16'sh0100, 2);
    sample(0, 0, "R8 prime");
    sample(0, 100, "R8 step quarter");
    sample(0, 100, "R8 decay 1");
    sample(0, 100, "R8 decay 2");
    gains(0, 0, 16'sh0300, 1);
    sample(0, 20, "R8 shift 1 gain 3");

    // R9: output rails
    do_reset();
    gains(16'sh7fff, 0, 0, 0);
    sample(30000, 0, "R9 positive rail");
    sample(-30000, 0, "R9 negative rail");
    sample(-32768, 32767, "R9 extreme error");

    // R10: full PID mix
    do_reset();
    gains(16'sh0200, 16'sh0040, 16'sh0180, 1);
    sample(200, 0, "R10 PID 1");
    sample(200, 50, "R10 PID 2");
    sample(200, 120, "R10 PID 3");
    sample(-100, 150, "R10 PID 4");

    // R1: mid-run reset clears filter history
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 mid-run reset u_out", longint'(u_out), 0);
    check("R1 mid-run reset strobe", longint'(out_valid), 0);
    rst = 1'b0;
    model_clear();
    gains(0, 0, 16'sh0100, 0);
    sample(0, 900, "R1 history cleared");

    repeat (3) @(negedge clk);
    check("R2 all results seen", longint'(sb.size()), 0);
    done = 1;
    summary();
  end
endmodule